// File: doc/BRIEF.md
# Eight-Pin GPIO Port with Peripheral Override Lanes

This block is one general-purpose I/O port of eight pins. Software programs a direction bit and an output bit per pin through a small register interface. For a pin set as an input, the output bit enables the pull-up. One global control bit turns off every pull-up that software requested. The block drives a pad model made of a tri-state output enable, an output value and a pull-up enable. It also receives the raw pad level.

Next to the registers sits a bank of override lanes, one set per pin. Any peripheral attached to the port can use them. Each lane pairs an enable with a value and takes over one control path on its own: pull-up, driver enable, driven value and digital input enable. A toggle lane inverts the stored output bit. The digital input is gated by its enable and goes to the peripherals without a synchronizer. The copy that software reads passes through a two-flop synchronizer.

Top module: `gpio_port`

## Requirements
- R1: While reset is held and after it is released, the direction register, the output register and the control register read 0. With no override active, every pin then has `pad_oe` = 0 and `pad_pu` = 0.
- R2: When a pin's pull-up override enable is 0, `pad_pu` is 1 exactly when direction = 0, output bit = 1 and global pull-up disable (control bit 0) = 0.
- R3: When a pin's pull-up override enable is 1, `pad_pu` equals that pin's pull-up override value. The direction bit, the output bit and the global disable have no effect.
- R4: `pad_oe` equals the direction override value when the direction override enable is 1. Otherwise it equals the direction register bit.
- R5: When `pad_oe` is 1, `pad_o` equals the value override value if the value override enable is 1, and the output register bit if it is 0. When `pad_oe` is 0, `pad_o` is 0.
- R6: For each clock edge in which a pin's toggle enable is 1, that pin's output register bit is inverted and stored. A register write to the output register in the same cycle takes priority over the toggle.
- R7: The input enable equals the input override value when the input override enable is 1. Otherwise it equals the inverse of `sleep`. `alt_di` is `pad_i` AND the input enable, with no clock delay.
- R8: Reading address 2 returns the gated input as it was two clock edges earlier (two-flop synchronizer).
- R9: Address 0 holds direction and address 1 holds the output bits. Address 3 holds the global pull-up disable in bit 0, and its other bits read 0. `rd_data` follows `addr` combinationally. Writes to address 2 change no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| addr | input | 2 | Register address for read and write |
| wr_en | input | 1 | Write strobe for the addressed register |
| wr_data | input | 8 | Write data |
| rd_data | output | 8 | Read data of the addressed register |
| sleep | input | 1 | Sleep state; disables digital inputs unless overridden |
| pu_ovr_en | input | 8 | Per-pin pull-up override enable |
| pu_ovr_val | input | 8 | Per-pin pull-up override value |
| dd_ovr_en | input | 8 | Per-pin driver-enable override enable |
| dd_ovr_val | input | 8 | Per-pin driver-enable override value |
| pv_ovr_en | input | 8 | Per-pin output-value override enable |
| pv_ovr_val | input | 8 | Per-pin output-value override value |
| tg_en | input | 8 | Per-pin toggle request for the output register |
| di_ovr_en | input | 8 | Per-pin input-enable override enable |
| di_ovr_val | input | 8 | Per-pin input-enable override value |
| pad_i | input | 8 | Raw pad levels |
| pad_oe | output | 8 | Pad output-driver enable |
| pad_o | output | 8 | Pad output value |
| pad_pu | output | 8 | Pad pull-up enable |
| alt_di | output | 8 | Gated, unsynchronized input to peripherals |

## Verification
The assertions check the time-related rules on every cycle. Registers must be cleared when reset is released. Each toggle must flip the stored bit unless a write takes priority. The register-visible input must lag the gated pad level by exactly two edges. Two relations always hold: an unoverridden pull-up never appears on a driven pin, and an unoverridden input never passes while asleep. Only the bench's sweeps show that the complete override truth tables are right, across every combination of register bits, global disable, sleep and override pairs. The same applies to the priority of writes over toggles and to the address decode.

// File: rtl/gpio_port.sv
module gpio_port #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [1:0]   addr,
  input  logic         wr_en,
  input  logic [W-1:0] wr_data,
  output logic [W-1:0] rd_data,
  input  logic         sleep,
  input  logic [W-1:0] pu_ovr_en,
  input  logic [W-1:0] pu_ovr_val,
  input  logic [W-1:0] dd_ovr_en,
  input  logic [W-1:0] dd_ovr_val,
  input  logic [W-1:0] pv_ovr_en,
  input  logic [W-1:0] pv_ovr_val,
  input  logic [W-1:0] tg_en,
  input  logic [W-1:0] di_ovr_en,
  input  logic [W-1:0] di_ovr_val,
  input  logic [W-1:0] pad_i,
  output logic [W-1:0] pad_oe,
  output logic [W-1:0] pad_o,
  output logic [W-1:0] pad_pu,
  output logic [W-1:0] alt_di
);
  localparam logic [1:0] A_DIR = 2'd0;
  localparam logic [1:0] A_OUT = 2'd1;
  localparam logic [1:0] A_IN  = 2'd2;
  localparam logic [1:0] A_CTL = 2'd3;

  logic [W-1:0] dir_q, out_q, sync1_q, sync2_q, in_en, gated;
  logic         pud_q;
  logic [1:0]   age_q;

  wire wr_dir = wr_en && (addr == A_DIR);
  wire wr_out = wr_en && (addr == A_OUT);
  wire wr_ctl = wr_en && (addr == A_CTL);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dir_q   <= '0;
      out_q   <= '0;
      pud_q   <= 1'b0;
      sync1_q <= '0;
      sync2_q <= '0;
      age_q   <= '0;
    end else begin
      if (wr_dir) dir_q <= wr_data;
      if (wr_out) out_q <= wr_data;
      else        out_q <= out_q ^ tg_en;
      if (wr_ctl) pud_q <= wr_data[0];
      sync1_q <= gated;
      sync2_q <= sync1_q;
      if (age_q != 2'd2) age_q <= age_q + 2'd1;
    end
  end

  assign pad_pu = (pu_ovr_en & pu_ovr_val) | (~pu_ovr_en & ~dir_q & out_q & {W{~pud_q}});
  assign pad_oe = (dd_ovr_en & dd_ovr_val) | (~dd_ovr_en & dir_q);
  assign pad_o  = pad_oe & ((pv_ovr_en & pv_ovr_val) | (~pv_ovr_en & out_q));
  assign in_en  = (di_ovr_en & di_ovr_val) | (~di_ovr_en & {W{~sleep}});
  assign gated  = pad_i & in_en;
  assign alt_di = gated;

  always_comb begin
    case (addr)
      A_DIR:   rd_data = dir_q;
      A_OUT:   rd_data = out_q;
      A_IN:    rd_data = sync2_q;
      default: rd_data = {{(W-1){1'b0}}, pud_q};
    endcase
  end

  AST_RST_CLEAR: assert property (@(posedge clk) $rose(rst_n) |-> (dir_q == '0 && out_q == '0 && !pud_q)); // R1
  AST_SYNC_LAG: assert property (@(posedge clk) disable iff (!rst_n)
    (age_q == 2'd2) |-> (sync2_q == $past(gated, 2))); // R8

  for (genvar i = 0; i < W; i++) begin : g_pin
    AST_TOGGLE_FLIP: assert property (@(posedge clk) disable iff (!rst_n)
      (tg_en[i] && !wr_out) |=> (out_q[i] != $past(out_q[i]))); // R6
    AST_PU_UNDRIVEN: assert property (@(posedge clk) disable iff (!rst_n)
      (!pu_ovr_en[i] && !dd_ovr_en[i] && pad_pu[i]) |-> !pad_oe[i]); // R2
    AST_SLEEP_BLOCKS: assert property (@(posedge clk) disable iff (!rst_n)
      (sleep && !di_ovr_en[i]) |-> !alt_di[i]); // R7
    AST_IDLE_LOW: assert property (@(posedge clk) disable iff (!rst_n)
      !pad_oe[i] |-> !pad_o[i]); // R5
  end
endmodule

// File: tb/sim_gpio_port.sv
module sim_gpio_port;
  localparam int CLK_PERIOD = 10;
  localparam int W = 8;

  logic clk = 1'b0, rst_n = 1'b0, wr_en = 1'b0, sleep = 1'b0;
  logic [1:0] addr = '0;
  logic [W-1:0] wr_data = '0, rd_data;
  logic [W-1:0] pu_ovr_en = '0, pu_ovr_val = '0, dd_ovr_en = '0, dd_ovr_val = '0;
  logic [W-1:0] pv_ovr_en = '0, pv_ovr_val = '0, tg_en = '0, di_ovr_en = '0, di_ovr_val = '0;
  logic [W-1:0] pad_i = '0, pad_oe, pad_o, pad_pu, alt_di;
  int checks = 0, fails = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  gpio_port #(.W(W)) u0 (.*);

  task automatic chk(string req, logic [W-1:0] act, logic [W-1:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(logic [1:0] a, logic [W-1:0] d);
    @(negedge clk); addr = a; wr_data = d; wr_en = 1'b1;
    @(posedge clk); #1 wr_en = 1'b0;
  endtask

  task automatic rd(logic [1:0] a, string req, logic [W-1:0] exp);
    @(negedge clk); addr = a; #1 chk(req, rd_data, exp);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      fails++; checks++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 chk("R1 oe in reset", pad_oe, '0);
    chk("R1 pu in reset", pad_pu, '0);
    @(negedge clk) rst_n = 1'b1;
    rd(2'd0, "R1 dir", '0);
    rd(2'd1, "R1 out", '0);
    rd(2'd3, "R1 ctl", '0);

    // R9 decode
    wr(2'd0, 8'h3C); wr(2'd1, 8'hA5); wr(2'd3, 8'hFF);
    rd(2'd0, "R9 dir", 8'h3C); rd(2'd1, "R9 out", 8'hA5); rd(2'd3, "R9 ctl", 8'h01);
    wr(2'd2, 8'h77);
    rd(2'd0, "R9 in-write dir", 8'h3C); rd(2'd1, "R9 in-write out", 8'hA5);
    rd(2'd3, "R9 in-write ctl", 8'h01);

    // R2-R5, R7 sweep
    for (int r = 0; r < 8; r++) begin
      logic dr, ou, pd;
      dr = r[2]; ou = r[1]; pd = r[0];
      wr(2'd0, {W{dr}}); wr(2'd1, {W{ou}}); wr(2'd3, {7'd0, pd});
      for (int c = 0; c < 4096; c++) begin
        logic e_pu, e_oe, e_o, e_ie;
        @(negedge clk);
        pu_ovr_en = {W{c[0]}}; pu_ovr_val = {W{c[1]}};
        dd_ovr_en = {W{c[2]}}; dd_ovr_val = {W{c[3]}};
        pv_ovr_en = {W{c[4]}}; pv_ovr_val = {W{c[5]}};
        di_ovr_en = {W{c[6]}}; di_ovr_val = {W{c[7]}};
        sleep = c[8]; pad_i = c[9] ? 8'hFF : 8'h00;
        if (c[11]) pad_i = c[10] ? 8'h96 : 8'h69;
        e_pu = c[0] ? c[1] : ({dr, ou, pd} == 3'b010);
        e_oe = c[2] ? c[3] : dr;
        e_o  = e_oe & (c[4] ? c[5] : ou);
        e_ie = c[6] ? c[7] : !c[8];
        #1;
        chk(c[0] ? "R3 pull-up override" : "R2 pull-up default", pad_pu, {W{e_pu}});
        chk("R4 driver enable", pad_oe, {W{e_oe}});
        chk("R5 driven value", pad_o, {W{e_o}});
        chk("R7 input gate", alt_di, pad_i & {W{e_ie}});
      end
    end
    @(negedge clk);
    pu_ovr_en = '0; dd_ovr_en = '0; pv_ovr_en = '0; di_ovr_en = '0; sleep = 1'b0; pad_i = '0;

    // R6 toggle
    wr(2'd1, 8'h0F);
    @(negedge clk) tg_en = 8'h03;
    repeat (3) @(posedge clk);
    #1 tg_en = '0;
    rd(2'd1, "R6 toggle x3", 8'h0C);
    rd(2'd1, "R6 toggle idle", 8'h0C);
    @(negedge clk); tg_en = 8'hFF; addr = 2'd1; wr_data = 8'hA5; wr_en = 1'b1;
    @(posedge clk); #1 wr_en = 1'b0; tg_en = '0;
    rd(2'd1, "R6 write wins", 8'hA5);

    // R8 sync lag
    repeat (3) @(posedge clk);
    @(negedge clk); addr = 2'd2; pad_i = 8'h5A;
    @(posedge clk); #1 chk("R8 lag edge1", rd_data, 8'h00);
    @(posedge clk); #1 chk("R8 lag edge2", rd_data, 8'h5A);
    @(negedge clk) sleep = 1'b1;
    repeat (2) @(posedge clk);
    #1 chk("R7 R8 sleep gated", rd_data, 8'h00);
    @(negedge clk); di_ovr_en = 8'hF0; di_ovr_val = 8'hF0;
    #1 chk("R7 override in sleep", alt_di, 8'h50);
    repeat (2) @(posedge clk);
    #1 chk("R8 override synced", rd_data, 8'h50);

    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule